// File: doc/BRIEF.md
# RAM Controller Interrupt and Control Register File

This block is the software-visible register file of an on-chip RAM controller. It sits on a simple 32-bit word bus (address, write enable, write data, registered read data). It holds an 11-source interrupt status register, and an interrupt mask that software cannot write directly. The mask changes only through a separate unmask port and a separate mask port. A single level interrupt output is asserted while any unmasked status bit is set.

Next to the interrupt logic it holds the controller's control registers: an error-handling control field, four fault-injection data words, a fault-injection syndrome and a fault-injection counter. Their values are driven out to the controller. Error-capture values (address and syndrome for correctable, uncorrectable and read-modify-write errors) arrive as plain inputs and are readable through the bus. A read-only implementation register reports the configured RAM size as a code. A read-only debug register reads as all ones.

Top module: `ramc_csr_top`

## Requirements
- R1: After reset, status reads 0x000, the mask (offset 0x04) reads 0x7FF, irq is low, the error control register (offset 0x10) reads 0xF, the debug register (offset 0x18) reads 0x0000FFFF, and every fault-injection output is zero.
- R2: A one-cycle pulse on bit k of evt_set sets status bit k (status at offset 0x00, bits 10:0). The bit then stays set until software clears it.
- R3: Writing offset 0x00 clears each status bit whose write-data bit is 1 and leaves the others unchanged. Status bits 31:11 always read zero.
- R4: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R5: Writes to the mask offset 0x04 leave the mask unchanged.
- R6: A write to offset 0x08 clears the mask bits at every 1 position of write data bits 10:0. Offset 0x08 reads zero.
- R7: A write to offset 0x0C sets the mask bits at every 1 position of write data bits 10:0. Offset 0x0C reads zero.
- R8: irq is high exactly when some status bit is 1 and its mask bit is 0. It takes its new value at the same clock edge that updates status or mask.
- R9: Offset 0x14 bits 3:0 read the size code (0: 64 KiB, 1: 128 KiB, 2: 256 KiB, 3: 512 KiB, 4: 1 MiB; the default is 1 MiB, code 4). Writes do not change it. Any other size fails elaboration.
- R10: Control registers keep only their implemented bits and drive them out. These are error control at 0x10 (bits 3:0), fault data words at 0x40, 0x44, 0x48 and 0x4C (32 bits each), fault syndrome at 0x60 (bits 15:0) and fault counter at 0x64 (bits 23:0). Bits above these read zero. The debug register ignores writes.
- R11: Capture offsets 0x20/0x24 (correctable address/syndrome), 0x28/0x2C (uncorrectable address/syndrome) and 0x30 (read-modify-write uncorrectable address) return the 20-bit address or 16-bit syndrome inputs, zero-extended. Writes there have no effect.
- R12: An address with bits 1:0 nonzero, or one that maps to no register, reads zero, and a write to it changes no register.
- R13: bus_rdata shows the register addressed in a cycle right after that cycle's clock edge, with the value held before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | NSRC | Per-source event pulses |
| ce_addr_in | input | CAP_W | Correctable error address capture |
| ce_syn_in | input | SYN_W | Correctable error syndrome capture |
| ue_addr_in | input | CAP_W | Uncorrectable error address capture |
| ue_syn_in | input | SYN_W | Uncorrectable error syndrome capture |
| rmw_addr_in | input | CAP_W | Read-modify-write uncorrectable address capture |
| irq | output | 1 | Level interrupt |
| err_ctrl_o | output | ERRC_W | Error control field |
| fi_data_o | output | FI_WORDS*32 | Fault-injection data words, word 0 in the low bits |
| fi_syn_o | output | SYN_W | Fault-injection syndrome |
| fi_cnt_o | output | FI_CNT_W | Fault-injection counter value |

## Verification
Register state, irq and every control output change at the clock edge that accepts a write or an event. The bench therefore drives inputs on the falling edge and samples one time unit after the next rising edge. bus_rdata is registered, so a read result is due right after the edge that follows the address. The bench's read task presents the address in its own cycle and samples only after that edge, so a read never overlaps the write whose effect it checks. The same-cycle collision of an event and a clear is driven inside one cycle, and the status is read in the cycle after it.

// File: rtl/ramc_csr_pkg.sv
package ramc_csr_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;

  typedef logic [IDX_W-1:0] widx_t;

  // word indices (byte offset / 4)
  localparam widx_t W_STAT  = 6'h00;
  localparam widx_t W_MASK  = 6'h01;
  localparam widx_t W_UNMSK = 6'h02;
  localparam widx_t W_MSK   = 6'h03;
  localparam widx_t W_ERRC  = 6'h04;
  localparam widx_t W_IMPL  = 6'h05;
  localparam widx_t W_DBG   = 6'h06;
  localparam widx_t W_CE_A  = 6'h08;
  localparam widx_t W_CE_S  = 6'h09;
  localparam widx_t W_UE_A  = 6'h0A;
  localparam widx_t W_UE_S  = 6'h0B;
  localparam widx_t W_RMW_A = 6'h0C;
  localparam widx_t W_FID0  = 6'h10;
  localparam widx_t W_FISY  = 6'h18;
  localparam widx_t W_FICN  = 6'h19;

  localparam logic [3:0] SIZE_BAD = 4'hF;

  function automatic logic [3:0] size_code(input int kib);
    case (kib)
      64:      return 4'd0;
      128:     return 4'd1;
      256:     return 4'd2;
      512:     return 4'd3;
      1024:    return 4'd4;
      default: return SIZE_BAD;
    endcase
  endfunction
endpackage

// File: rtl/ramc_irq_core.sv
module ramc_irq_core #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_we,
  input  logic            unmask_we,
  input  logic            mask_we,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic [NSRC-1:0] status_q, mask_q, status_nx, mask_nx;

  always_comb begin
    status_nx = status_q;
    if (clr_we) status_nx = status_nx & ~wbits;
    status_nx = status_nx | evt_i;   // set wins over clear
    mask_nx = mask_q;
    if (unmask_we) mask_nx = mask_nx & ~wbits;
    if (mask_we)   mask_nx = mask_nx | wbits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_o    <= 1'b0;
    end else begin
      status_q <= status_nx;
      mask_q   <= mask_nx;
      irq_o    <= |(status_nx & ~mask_nx);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_q & ~mask_q));
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  assert_clear_only_by_write_R3: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));
  assert_mask_ro_R5: assert property (@(posedge clk) disable iff (rst)
    !(unmask_we || mask_we) |=> $stable(mask_q));
  assert_unmask_clears_R6: assert property (@(posedge clk) disable iff (rst)
    unmask_we |=> ((mask_q & $past(wbits)) == '0));
  assert_mask_sets_R7: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> ((mask_q & $past(wbits)) == $past(wbits)));
endmodule

// File: rtl/ramc_ctl_store.sv
module ramc_ctl_store
  import ramc_csr_pkg::*;
#(
  parameter int ERRC_W   = 4,
  parameter int FI_WORDS = 4,
  parameter int SYN_W    = 16,
  parameter int FI_CNT_W = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  widx_t                      idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [ERRC_W-1:0]          errc_o,
  output logic [FI_WORDS*DATA_W-1:0] fi_data_o,
  output logic [SYN_W-1:0]           fi_syn_o,
  output logic [FI_CNT_W-1:0]        fi_cnt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      errc_o   <= '1;
      fi_syn_o <= '0;
      fi_cnt_o <= '0;
    end else if (we) begin
      if (idx == W_ERRC) errc_o   <= wdata[ERRC_W-1:0];
      if (idx == W_FISY) fi_syn_o <= wdata[SYN_W-1:0];
      if (idx == W_FICN) fi_cnt_o <= wdata[FI_CNT_W-1:0];
    end
  end

  for (genvar i = 0; i < FI_WORDS; i++) begin : g_fi
    localparam widx_t MY_IDX = W_FID0 + widx_t'(i);
    always_ff @(posedge clk) begin
      if (rst) fi_data_o[i*DATA_W +: DATA_W] <= '0;
      else if (we && idx == MY_IDX) fi_data_o[i*DATA_W +: DATA_W] <= wdata;
    end
  end

  assert_errc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(we && idx == W_ERRC) |=> $stable(errc_o));
endmodule

// File: rtl/ramc_csr_top.sv
module ramc_csr_top
  import ramc_csr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NSRC     = 11,
  parameter int RAM_KIB  = 1024,
  parameter int CAP_W    = 20,
  parameter int SYN_W    = 16,
  parameter int ERRC_W   = 4,
  parameter int FI_WORDS = 4,
  parameter int FI_CNT_W = 24,
  parameter int DBG_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NSRC-1:0]            evt_set,
  input  logic [CAP_W-1:0]           ce_addr_in,
  input  logic [SYN_W-1:0]           ce_syn_in,
  input  logic [CAP_W-1:0]           ue_addr_in,
  input  logic [SYN_W-1:0]           ue_syn_in,
  input  logic [CAP_W-1:0]           rmw_addr_in,
  output logic                       irq,
  output logic [ERRC_W-1:0]          err_ctrl_o,
  output logic [FI_WORDS*DATA_W-1:0] fi_data_o,
  output logic [SYN_W-1:0]           fi_syn_o,
  output logic [FI_CNT_W-1:0]        fi_cnt_o
);
  localparam logic [3:0] SIZE_CODE = size_code(RAM_KIB);
  localparam logic [DBG_W-1:0] DBG_VAL = '1;

  if (SIZE_CODE == SIZE_BAD) begin : g_bad_size
    $error("ramc_csr_top: unsupported RAM_KIB %0d", RAM_KIB);
  end

  logic hi_ok, sel_ok;
  widx_t idx;
  if (ADDR_W > IDX_W + 2) begin : g_hi
    assign hi_ok = (bus_addr[ADDR_W-1:IDX_W+2] == '0);
  end else begin : g_nohi
    assign hi_ok = 1'b1;
  end
  assign idx    = bus_addr[IDX_W+1:2];
  assign sel_ok = hi_ok && (bus_addr[1:0] == 2'b00);

  logic wr_ok;
  assign wr_ok = bus_we && sel_ok;

  logic [NSRC-1:0] status, mask;

  ramc_irq_core #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .evt_i(evt_set),
    .clr_we(wr_ok && idx == W_STAT),
    .unmask_we(wr_ok && idx == W_UNMSK),
    .mask_we(wr_ok && idx == W_MSK),
    .wbits(bus_wdata[NSRC-1:0]),
    .status_o(status), .mask_o(mask), .irq_o(irq)
  );

  ramc_ctl_store #(
    .ERRC_W(ERRC_W), .FI_WORDS(FI_WORDS), .SYN_W(SYN_W), .FI_CNT_W(FI_CNT_W)
  ) u_store (
    .clk(clk), .rst(rst), .we(wr_ok), .idx(idx), .wdata(bus_wdata),
    .errc_o(err_ctrl_o), .fi_data_o(fi_data_o), .fi_syn_o(fi_syn_o),
    .fi_cnt_o(fi_cnt_o)
  );

  logic [DATA_W-1:0] rd_nx;
  always_comb begin
    rd_nx = '0;
    if (sel_ok) begin
      case (idx)
        W_STAT:  rd_nx = DATA_W'(status);
        W_MASK:  rd_nx = DATA_W'(mask);
        W_ERRC:  rd_nx = DATA_W'(err_ctrl_o);
        W_IMPL:  rd_nx = DATA_W'(SIZE_CODE);
        W_DBG:   rd_nx = DATA_W'(DBG_VAL);
        W_CE_A:  rd_nx = DATA_W'(ce_addr_in);
        W_CE_S:  rd_nx = DATA_W'(ce_syn_in);
        W_UE_A:  rd_nx = DATA_W'(ue_addr_in);
        W_UE_S:  rd_nx = DATA_W'(ue_syn_in);
        W_RMW_A: rd_nx = DATA_W'(rmw_addr_in);
        W_FISY:  rd_nx = DATA_W'(fi_syn_o);
        W_FICN:  rd_nx = DATA_W'(fi_cnt_o);
        default: rd_nx = '0;
      endcase
      for (int i = 0; i < FI_WORDS; i++)
        if (idx == W_FID0 + widx_t'(i)) rd_nx = fi_data_o[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nx;
  end

  assert_unmapped_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));
  assert_reserved_status_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_ok && idx == W_STAT) |=> (bus_rdata[DATA_W-1:NSRC] == '0));
endmodule

// File: tb/ramc_csr_top_test.sv
module ramc_csr_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] evt_set = '0;
  logic [19:0] ce_addr_in = '0, ue_addr_in = '0, rmw_addr_in = '0;
  logic [15:0] ce_syn_in = '0, ue_syn_in = '0;
  logic        irq;
  logic [3:0]  err_ctrl_o;
  logic [127:0] fi_data_o;
  logic [15:0] fi_syn_o;
  logic [23:0] fi_cnt_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramc_csr_top uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .ce_addr_in(ce_addr_in), .ce_syn_in(ce_syn_in), .ue_addr_in(ue_addr_in),
    .ue_syn_in(ue_syn_in), .rmw_addr_in(rmw_addr_in), .irq(irq),
    .err_ctrl_o(err_ctrl_o), .fi_data_o(fi_data_o), .fi_syn_o(fi_syn_o),
    .fi_cnt_o(fi_cnt_o)
  );

  // op: 0 write then check irq, 1 read then check data, 2 event pulse then check irq
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 8'h04, 32'h0, 32'h7FF, 1'b0, 4'd1},          // R1 mask after reset
    '{2'd2, 8'h00, 32'h005, 32'h0, 1'b0, 4'd2},          // R2 events while masked
    '{2'd1, 8'h00, 32'h0, 32'h005, 1'b0, 4'd2},          // R2
    '{2'd0, 8'h08, 32'h004, 32'h0, 1'b1, 4'd6},          // R6 unmask bit 2
    '{2'd1, 8'h04, 32'h0, 32'h7FB, 1'b0, 4'd6},          // R6
    '{2'd1, 8'h08, 32'h0, 32'h0, 1'b0, 4'd6},            // R6 reads zero
    '{2'd0, 8'h04, 32'h0, 32'h0, 1'b1, 4'd5},            // R5 direct write
    '{2'd1, 8'h04, 32'h0, 32'h7FB, 1'b0, 4'd5},          // R5
    '{2'd0, 8'h0C, 32'h004, 32'h0, 1'b0, 4'd7},          // R7 mask bit 2
    '{2'd1, 8'h0C, 32'h0, 32'h0, 1'b0, 4'd7},            // R7 reads zero
    '{2'd0, 8'h08, 32'h7FF, 32'h0, 1'b1, 4'd8},          // R8 unmask all
    '{2'd0, 8'h00, 32'hFFFFF001, 32'h0, 1'b1, 4'd3},     // R3 clear bit 0
    '{2'd1, 8'h00, 32'h0, 32'h004, 1'b0, 4'd3},          // R3
    '{2'd0, 8'h00, 32'h004, 32'h0, 1'b0, 4'd8},          // R8 last source cleared
    '{2'd2, 8'h00, 32'h400, 32'h0, 1'b1, 4'd2},          // R2 top source
    '{2'd0, 8'h0C, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd7},     // R7 mask all
    '{2'd1, 8'h04, 32'h0, 32'h7FF, 1'b0, 4'd7},          // R7
    '{2'd0, 8'h00, 32'h400, 32'h0, 1'b0, 4'd3},          // R3
    '{2'd1, 8'h00, 32'h0, 32'h0, 1'b0, 4'd3},            // R3
    '{2'd0, 8'h10, 32'hFFFFFFF5, 32'h0, 1'b0, 4'd10},    // R10 err ctrl
    '{2'd1, 8'h10, 32'h0, 32'h5, 1'b0, 4'd10},           // R10
    '{2'd0, 8'h64, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd10},    // R10 counter
    '{2'd1, 8'h64, 32'h0, 32'h00FFFFFF, 1'b0, 4'd10},    // R10
    '{2'd0, 8'h60, 32'h12345678, 32'h0, 1'b0, 4'd10},    // R10 syndrome
    '{2'd1, 8'h60, 32'h0, 32'h5678, 1'b0, 4'd10},        // R10
    '{2'd0, 8'h4C, 32'hDEADBEEF, 32'h0, 1'b0, 4'd10},    // R10 data word 3
    '{2'd1, 8'h4C, 32'h0, 32'hDEADBEEF, 1'b0, 4'd10},    // R10
    '{2'd0, 8'h14, 32'hF, 32'h0, 1'b0, 4'd9},            // R9 write ignored
    '{2'd1, 8'h14, 32'h0, 32'h4, 1'b0, 4'd9},            // R9 code for 1 MiB
    '{2'd0, 8'h18, 32'h0, 32'h0, 1'b0, 4'd10},           // R10 debug ro
    '{2'd1, 8'h18, 32'h0, 32'hFFFF, 1'b0, 4'd10},        // R10
    '{2'd2, 8'h00, 32'h001, 32'h0, 1'b0, 4'd12},         // R12 set a bit
    '{2'd0, 8'h01, 32'h001, 32'h0, 1'b0, 4'd12},         // R12 misaligned clear
    '{2'd1, 8'h00, 32'h0, 32'h001, 1'b0, 4'd12}          // R12 status kept
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req,
                       input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [10:0] b);
    @(negedge clk);
    evt_set = b;
    @(posedge clk); #1;
    evt_set = '0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state at the ports
    check({31'b0, irq}, 32'h0, 1, "irq after reset");
    check({28'b0, err_ctrl_o}, 32'hF, 1, "err_ctrl_o after reset");
    check(fi_data_o[31:0] | fi_data_o[127:96], 32'h0, 1, "fi_data_o after reset");
    rd(8'h00, r); check(r, 32'h0, 1, "status after reset");
    rd(8'h18, r); check(r, 32'hFFFF, 1, "debug after reset");

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: begin
          wr(VEC[i].addr, VEC[i].data);
          check({31'b0, irq}, {31'b0, VEC[i].exp_irq}, int'(VEC[i].req), "irq after write");
        end
        2'd1: begin
          rd(VEC[i].addr, r);
          check(r, VEC[i].exp, int'(VEC[i].req), "read data");
        end
        default: begin
          pulse(VEC[i].data[10:0]);
          check({31'b0, irq}, {31'b0, VEC[i].exp_irq}, int'(VEC[i].req), "irq after event");
        end
      endcase
    end

    // R10 values reach the output ports
    check({28'b0, err_ctrl_o}, 32'h5, 10, "err_ctrl_o");
    check({8'b0, fi_cnt_o}, 32'h00FFFFFF, 10, "fi_cnt_o");
    check(fi_data_o[127:96], 32'hDEADBEEF, 10, "fi_data_o word 3");
    check({16'b0, fi_syn_o}, 32'h5678, 10, "fi_syn_o");

    // R12 unmapped address
    wr(8'h7C, 32'hFFFFFFFF);
    rd(8'h7C, r); check(r, 32'h0, 12, "unmapped read");
    rd(8'h10, r); check(r, 32'h5, 12, "err ctrl after unmapped write");

    // R4 event and clear on the same bit in one cycle
    @(negedge clk);
    bus_addr = 8'h00; bus_we = 1'b1; bus_wdata = 32'h009; evt_set = 11'h008;
    @(posedge clk); #1;
    bus_we = 1'b0; evt_set = '0;
    rd(8'h00, r); check(r, 32'h008, 4, "set wins over clear");

    // R11 capture inputs, zero-extended, write ignored
    ce_addr_in = 20'hABCDE; ce_syn_in = 16'h1234;
    ue_addr_in = 20'hFFFFF; ue_syn_in = 16'hBEEF; rmw_addr_in = 20'h00F0F;
    wr(8'h20, 32'h0);
    rd(8'h20, r); check(r, 32'h000ABCDE, 11, "ce addr");
    rd(8'h24, r); check(r, 32'h00001234, 11, "ce syndrome");
    rd(8'h28, r); check(r, 32'h000FFFFF, 11, "ue addr");
    rd(8'h2C, r); check(r, 32'h0000BEEF, 11, "ue syndrome");
    rd(8'h30, r); check(r, 32'h00000F0F, 11, "rmw addr");

    // R13 read returns pre-write value in the write cycle
    @(negedge clk);
    bus_addr = 8'h10; bus_we = 1'b1; bus_wdata = 32'hA;
    @(posedge clk); #1;
    bus_we = 1'b0;
    check(bus_rdata, 32'h5, 13, "read during write shows old value");
    rd(8'h10, r); check(r, 32'hA, 13, "read after write");

    // R1 reset re-applied
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk) rst = 1'b0;
    check({28'b0, err_ctrl_o}, 32'hF, 1, "err_ctrl_o after second reset");
    check({8'b0, fi_cnt_o}, 32'h0, 1, "fi_cnt_o after second reset");
    rd(8'h04, r); check(r, 32'h7FF, 1, "mask after second reset");
    rd(8'h00, r); check(r, 32'h0, 1, "status after second reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule